// File: doc/BRIEF.md
# Majority-Clocked Stream Cipher Generator

This block produces a keystream from three linear feedback shift registers of unequal length. After the first phase, a register steps only when its clocking bit agrees with the majority of the three clocking bits. Stepping is therefore irregular: on most cycles two registers move, and all three move when their clocking bits match. Each keystream bit is the XOR of the three most significant bits.

A single `start` pulse samples a 64-bit session key and a 22-bit frame number. The block then runs without further help. It clears its registers and shifts in the key and frame number with all registers stepping. It runs a fixed number of majority-clocked warm-up steps whose output is discarded. It then delivers a burst of keystream bits, each marked with a valid flag. An enable input pauses every phase. A plaintext bit presented with a valid keystream bit comes back as a ciphertext bit on the same cycle.

Top module: `maj_stream_keygen`

## Requirements
- R1: Out of synchronous reset, and whenever no sequence is running, `busy`, `ks_valid`, `ks_bit` and `ct_bit` are all 0. No register steps in that state.
- R2: The `start` edge clears all three registers. The next 86 enabled cycles step every register. Each of these cycles XORs one bit into bit 0 of each register: the key, least significant bit first, then the frame number, least significant bit first. The key and frame number are captured at the `start` edge, and later changes on those inputs are ignored.
- R3: The registers are 19, 22 and 23 bits long. Bit 0 is the input end and the top bit is the output bit. The feedback is the XOR of these taps: 13, 16, 17 and 18 in the 19-bit register; 20 and 21 in the 22-bit register; 7, 20, 21 and 22 in the 23-bit register.
- R4: After the load phase, the clocking bits are bit 8 of the 19-bit register and bit 10 of each of the other two. A register steps exactly when its clocking bit equals the majority of the three clocking bits, so on every such step at least two registers move.
- R5: The load phase is followed by 100 enabled majority-clocked steps with `ks_valid` low. With `en` held high, the first `ks_valid` appears after the 187th rising edge that follows the edge sampling `start`.
- R6: Exactly 228 keystream bits are flagged valid per sequence. `busy` is low once the last bit has been presented, and no further valid bits appear until the next `start`.
- R7: While `ks_valid` is high, `ks_bit` is the XOR of the three register output bits after the latest step, and `ct_bit` equals `ks_bit` XOR `pt_bit`.
- R8: A cycle with `en` low changes no register state, and the cycle after it shows `ks_valid` low. The keystream that follows is the same as with `en` always high.
- R9: Asserting `start` while a sequence is running abandons it and begins a complete new sequence with the newly presented key and frame number. `ks_valid` is low in the cycle after the `start` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin (or restart) a sequence; samples key and frame |
| en | input | 1 | Cycle enable for every phase |
| key | input | 64 | Session key |
| frame | input | 22 | Frame number |
| pt_bit | input | 1 | Plaintext bit to be combined |
| ks_bit | output | 1 | Keystream bit, 0 when not valid |
| ks_valid | output | 1 | Keystream bit valid |
| ct_bit | output | 1 | Ciphertext bit, 0 when not valid |
| busy | output | 1 | A sequence is in progress |

## Verification
The hardest case to reach is an enable gap that falls at a phase boundary or in the middle of the burst. A wrong hold or a lost step there is hidden until the stream has drifted. The bench therefore drives `en` at random densities over whole sequences and compares every valid bit against its own model of the algorithm. Restarts are issued in both the warm-up and the burst phases. Key and frame inputs are scrambled after `start` to show that the sampled values alone determine the stream.

// File: rtl/msk_pkg.sv
package msk_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_WARM = 2'd2,
      PH_EMIT = 2'd3
   } msk_phase_e;
endpackage

// File: rtl/msk_lfsr.sv
module msk_lfsr #(
   parameter int unsigned LEN      = 19,
   parameter logic [31:0] TAP_MASK = 32'h0007_2000,
   parameter int unsigned CLK_POS  = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic step,
   input  logic inject,
   output logic msb,
   output logic ckbit
);
   if (LEN < 3 || LEN > 32) begin : g_bad_len
      $error("msk_lfsr: LEN out of range");
   end
   if (CLK_POS >= LEN) begin : g_bad_ck
      $error("msk_lfsr: CLK_POS beyond register");
   end

   localparam logic [LEN-1:0] TAPS = TAP_MASK[LEN-1:0];

   logic [LEN-1:0] r_q;
   logic           fb;

   assign fb    = ^(r_q & TAPS);
   assign msb   = r_q[LEN-1];
   assign ckbit = r_q[CLK_POS];

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         r_q <= '0;
      end else if (step) begin
         r_q <= {r_q[LEN-2:0], fb ^ inject};
      end
   end
endmodule

// File: rtl/msk_clock_vote.sv
module msk_clock_vote #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] ck,
   input  logic         active,
   input  logic         regular,
   output logic [N-1:0] step
);
   if (N % 2 == 0) begin : g_bad_n
      $error("msk_clock_vote: N must be odd");
   end

   localparam int unsigned CW   = $clog2(N + 1);
   localparam int unsigned HALF = N / 2;

   logic [CW-1:0] ones;
   logic          maj;

   always_comb begin
      ones = '0;
      for (int i = 0; i < N; i++) begin
         ones = ones + CW'(ck[i]);
      end
      maj = (ones > CW'(HALF));
   end

   for (genvar g = 0; g < N; g++) begin : g_step
      assign step[g] = active & (regular | (ck[g] == maj));
   end
endmodule

// File: rtl/msk_sequencer.sv
module msk_sequencer
   import msk_pkg::*;
#(
   parameter int unsigned KEY_W    = 64,
   parameter int unsigned FRM_W    = 22,
   parameter int unsigned WARM_CYC = 100,
   parameter int unsigned BURST    = 228
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             en,
   input  logic [KEY_W-1:0] key,
   input  logic [FRM_W-1:0] frame,
   output msk_phase_e       phase,
   output logic             active,
   output logic             regular,
   output logic             inject,
   output logic             emit_step
);
   localparam int unsigned LOAD_N = KEY_W + FRM_W;
   localparam int unsigned MAX_N  = (LOAD_N > WARM_CYC) ?
                                    ((LOAD_N > BURST) ? LOAD_N : BURST) :
                                    ((WARM_CYC > BURST) ? WARM_CYC : BURST);
   localparam int unsigned CNT_W  = $clog2(MAX_N + 1);

   if (WARM_CYC < 1 || BURST < 1) begin : g_bad_len
      $error("msk_sequencer: WARM_CYC and BURST must be at least 1");
   end

   logic [LOAD_N-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   msk_phase_e        ph_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         sr_q  <= '0;
      end else if (start) begin
         ph_q  <= PH_LOAD;
         cnt_q <= '0;
         sr_q  <= {frame, key};
      end else if (en) begin
         case (ph_q)
            PH_LOAD: begin
               sr_q <= sr_q >> 1;
               if (cnt_q == CNT_W'(LOAD_N - 1)) begin
                  ph_q  <= PH_WARM;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_WARM: begin
               if (cnt_q == CNT_W'(WARM_CYC - 1)) begin
                  ph_q  <= PH_EMIT;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_EMIT: begin
               if (cnt_q == CNT_W'(BURST - 1)) begin
                  ph_q  <= PH_IDLE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign phase     = ph_q;
   assign active    = en & ~start & (ph_q != PH_IDLE);
   assign regular   = (ph_q == PH_LOAD);
   assign inject    = (ph_q == PH_LOAD) & sr_q[0];
   assign emit_step = active & (ph_q == PH_EMIT);
endmodule

// File: rtl/maj_stream_keygen.sv
module maj_stream_keygen
   import msk_pkg::*;
#(
   parameter int unsigned KEY_W    = 64,
   parameter int unsigned FRM_W    = 22,
   parameter int unsigned WARM_CYC = 100,
   parameter int unsigned BURST    = 228,
   parameter int unsigned LEN_A    = 19,
   parameter int unsigned LEN_B    = 22,
   parameter int unsigned LEN_C    = 23,
   parameter logic [31:0] TAPS_A   = 32'h0007_2000,
   parameter logic [31:0] TAPS_B   = 32'h0030_0000,
   parameter logic [31:0] TAPS_C   = 32'h0070_0080,
   parameter int unsigned CKP_A    = 8,
   parameter int unsigned CKP_B    = 10,
   parameter int unsigned CKP_C    = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             en,
   input  logic [KEY_W-1:0] key,
   input  logic [FRM_W-1:0] frame,
   input  logic             pt_bit,
   output logic             ks_bit,
   output logic             ks_valid,
   output logic             ct_bit,
   output logic             busy
);
   localparam int unsigned NREG = 3;
   localparam int unsigned LENS [NREG] = '{LEN_A, LEN_B, LEN_C};
   localparam logic [31:0] TAPS [NREG] = '{TAPS_A, TAPS_B, TAPS_C};
   localparam int unsigned CKPS [NREG] = '{CKP_A, CKP_B, CKP_C};

   msk_phase_e      phase_w;
   logic            active_w;
   logic            regular_w;
   logic            inject_w;
   logic            emit_w;
   logic [NREG-1:0] step_w;
   logic [NREG-1:0] ck_w;
   logic [NREG-1:0] msb_w;
   logic            valid_q;

   msk_sequencer #(
      .KEY_W(KEY_W), .FRM_W(FRM_W), .WARM_CYC(WARM_CYC), .BURST(BURST)
   ) u_seq (
      .clk(clk), .rst(rst), .start(start), .en(en), .key(key), .frame(frame),
      .phase(phase_w), .active(active_w), .regular(regular_w),
      .inject(inject_w), .emit_step(emit_w)
   );

   msk_clock_vote #(.N(NREG)) u_vote (
      .ck(ck_w), .active(active_w), .regular(regular_w), .step(step_w)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      msk_lfsr #(
         .LEN(LENS[g]), .TAP_MASK(TAPS[g]), .CLK_POS(CKPS[g])
      ) u_lfsr (
         .clk(clk), .rst(rst), .clear(start), .step(step_w[g]),
         .inject(inject_w), .msb(msb_w[g]), .ckbit(ck_w[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst || start) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= emit_w;
      end
   end

   assign ks_valid = valid_q;
   assign ks_bit   = valid_q & (^msb_w);
   assign ct_bit   = ks_bit ^ (pt_bit & valid_q);
   assign busy     = (phase_w != PH_IDLE);
endmodule

// File: rtl/msk_checks.sv
module msk_checks
   import msk_pkg::*;
#(
   parameter int unsigned BURST = 228
) (
   input logic       clk,
   input logic       rst,
   input logic       start,
   input logic       en,
   input msk_phase_e phase,
   input logic [2:0] step,
   input logic [2:0] ckb,
   input logic [2:0] msb,
   input logic       ks_valid,
   input logic       busy
);
   localparam int unsigned VW = $clog2(BURST + 2);
   logic [VW-1:0] nvalid_q;

   always_ff @(posedge clk) begin
      if (rst || start) begin
         nvalid_q <= '0;
      end else if (ks_valid && nvalid_q <= VW'(BURST)) begin
         nvalid_q <= nvalid_q + 1'b1;
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |-> (step == 3'b000));

   // R2
   load_all_step_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_LOAD && en && !start) |-> (step == 3'b111));

   // R4
   vote_two_min_chk: assert property (@(posedge clk) disable iff (rst)
      ((phase == PH_WARM || phase == PH_EMIT) && en && !start)
         |-> ($countones(step) >= 2));

   // R4
   loner_disagrees_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(step) == 2) |-> (ckb == step || ckb == ~step));

   // R8
   hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!en && !start) |=> ($stable(msb) && !ks_valid));

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> (busy && !ks_valid));

   // R6
   burst_len_chk: assert property (@(posedge clk) disable iff (rst)
      nvalid_q <= VW'(BURST));
endmodule

bind maj_stream_keygen msk_checks #(.BURST(BURST)) u_chk (
   .clk(clk), .rst(rst), .start(start), .en(en), .phase(phase_w),
   .step(step_w), .ckb(ck_w), .msb(msb_w), .ks_valid(ks_valid), .busy(busy)
);

// File: tb/maj_stream_keygen_tb.sv
module maj_stream_keygen_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        en = 1'b0;
   logic [63:0] key = '0;
   logic [21:0] frame = '0;
   logic        pt_bit = 1'b0;
   logic        ks_bit, ks_valid, ct_bit, busy;

   int n_chk = 0;
   int n_bad = 0;

   logic [18:0] ra;
   logic [21:0] rb;
   logic [22:0] rc;
   bit          exp_ks [228];

   always #4 clk = ~clk;

   maj_stream_keygen u_dut (
      .clk(clk), .rst(rst), .start(start), .en(en), .key(key), .frame(frame),
      .pt_bit(pt_bit), .ks_bit(ks_bit), .ks_valid(ks_valid), .ct_bit(ct_bit),
      .busy(busy)
   );

   task automatic check(input bit ok, input string req, input longint act,
                        input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic ref_step(input bit regular, input bit inj);
      bit m, sa, sb, sc, fa, fb, fc;
      m  = (ra[8] & rb[10]) | (ra[8] & rc[10]) | (rb[10] & rc[10]);
      sa = regular | (ra[8] == m);
      sb = regular | (rb[10] == m);
      sc = regular | (rc[10] == m);
      fa = ra[13] ^ ra[16] ^ ra[17] ^ ra[18];
      fb = rb[20] ^ rb[21];
      fc = rc[7] ^ rc[20] ^ rc[21] ^ rc[22];
      if (sa) ra = {ra[17:0], fa ^ inj};
      if (sb) rb = {rb[20:0], fb ^ inj};
      if (sc) rc = {rc[21:0], fc ^ inj};
   endtask

   task automatic ref_gen(input logic [63:0] k, input logic [21:0] f);
      ra = '0; rb = '0; rc = '0;
      for (int i = 0; i < 64; i++) ref_step(1'b1, k[i]);
      for (int i = 0; i < 22; i++) ref_step(1'b1, f[i]);
      for (int i = 0; i < 100; i++) ref_step(1'b0, 1'b0);
      for (int i = 0; i < 228; i++) begin
         ref_step(1'b0, 1'b0);
         exp_ks[i] = ra[18] ^ rb[21] ^ rc[22];
      end
   endtask

   // Runs one sequence; abort_after > 0 stops early without end checks.
   task automatic run_burst(input logic [63:0] k, input logic [21:0] f,
                            input int en_pct, input bit scramble,
                            input int abort_after);
      int n = 0, got = 0, mism = 0, ctbad = 0, lowbad = 0, lat = -1;
      bit en_prev = 1'b1;
      ref_gen(k, f);
      key = k; frame = f; start = 1'b1; en = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      // R9: no valid bit right after the start edge
      check(ks_valid == 1'b0 && busy == 1'b1, "R9", ks_valid, 0);
      while (got < 228 && n < 4000 && !(abort_after > 0 && n >= abort_after)) begin
         if (ks_valid) begin
            if (ks_bit != exp_ks[got]) mism++;
            if (lat < 0) lat = n;
            got++;
         end
         if (!en_prev && ks_valid) lowbad++;
         pt_bit = 1'($urandom);
         #1;
         if (ct_bit != (ks_valid ? (ks_bit ^ pt_bit) : 1'b0)) ctbad++;
         en = (($urandom % 100) < en_pct);
         en_prev = en;
         if (scramble) begin
            key = {$urandom, $urandom};
            frame = 22'($urandom);
         end
         @(posedge clk); #1;
         n++;
      end
      if (abort_after > 0) return;
      // R2 R3 R4: stream matches the model (load order, taps, vote)
      check(mism == 0, "R3", mism, 0);
      // R7
      check(ctbad == 0, "R7", ctbad, 0);
      // R6
      check(got == 228 && busy == 1'b0, "R6", got, 228);
      if (en_pct == 100) check(lat == 187, "R5", lat, 187);
      else check(lowbad == 0, "R8", lowbad, 0);
      en = 1'b1;
      lowbad = 0;
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); #1;
         if (ks_valid || busy || ks_bit || ct_bit) lowbad++;
      end
      // R6 R1: nothing after the burst
      check(lowbad == 0, "R6", lowbad, 0);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A5E_0C11));
      pt_bit = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      #1;
      // R1
      check(!busy && !ks_valid && !ks_bit && !ct_bit, "R1",
            {busy, ks_valid, ks_bit, ct_bit}, 0);
      en = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      check(!busy && !ks_valid, "R1", {busy, ks_valid}, 0);

      // directed corners, en always on
      run_burst(64'h0, 22'h0, 100, 1'b0, 0);
      run_burst('1, 22'h3FFFFF, 100, 1'b0, 0);
      run_burst(64'h1, 22'h0, 100, 1'b0, 0);       // R2 key LSB first
      run_burst(64'h0, 22'h1, 100, 1'b0, 0);       // R2 frame LSB first
      run_burst(64'h8000_0000_0000_0000, 22'h200000, 100, 1'b0, 0);

      // R8: random enable density
      for (int t = 0; t < 4; t++) begin
         run_burst({$urandom, $urandom}, 22'($urandom), 30 + 15 * t, 1'b0, 0);
      end

      // R2: inputs scrambled after start are ignored
      run_burst({$urandom, $urandom}, 22'($urandom), 100, 1'b1, 0);
      run_burst({$urandom, $urandom}, 22'($urandom), 60, 1'b1, 0);

      // R9: restart during warm-up, then during the burst
      run_burst({$urandom, $urandom}, 22'($urandom), 100, 1'b0, 150);
      run_burst(64'hDEAD_BEEF_0123_4567, 22'h2A5A5, 100, 1'b0, 0);
      run_burst({$urandom, $urandom}, 22'($urandom), 100, 1'b0, 300);
      run_burst({$urandom, $urandom}, 22'($urandom), 70, 1'b0, 0);

      // R1: reset mid-sequence returns to idle
      key = {$urandom, $urandom};
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      repeat (50) @(posedge clk);
      #1;
      rst = 1'b1;
      @(posedge clk); #1;
      rst = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check(!busy && !ks_valid, "R1", {busy, ks_valid}, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule